// File: doc/BRIEF.md
# Keyboard Input Register Interface

This block sits between a keyboard front end and a 16-bit processor bus and presents two registers to software: a status word and a data word. The front end delivers each character as a one-cycle strobe together with an 8-bit code. The block latches one character and raises a ready flag. It then refuses further characters until the processor has read the data word.

Software either polls the ready flag in the status word or sets an interrupt-enable bit in that same word. When that bit is set, the block drives an interrupt request for as long as a character is waiting. Reads are registered: the selected word appears on the read bus in the cycle after the read strobe and stays there until the next read. In the system memory map the status word is decoded at xFE00 and the data word at xFE02. The bus decoder reduces that address to the one-bit register select used here.

Top module: `kbd_regs`

## Requirements
- R1: `reg_sel` = 0 selects the status word and `reg_sel` = 1 selects the data word. A read strobe loads the selected word into `rd_data` at the next clock edge, and `rd_data` holds that value until the next read strobe.
- R2: A data-word read returns the latched character code in bits [7:0] and zero in bits [15:8].
- R3: A character strobe that arrives while the ready flag is 0 latches the code and sets the ready flag at the same clock edge.
- R4: While the ready flag is 1, character strobes are dropped, and the latched code and the flag are left unchanged.
- R5: A data-word read clears the ready flag at its clock edge. The next strobe is accepted.
- R6: A status-word write copies `wr_data[14]` into the interrupt-enable bit and ignores the other bits. A data-word write has no effect.
- R7: A status-word read returns the ready flag in bit 15 and the interrupt-enable bit in bit 14. Bits [13:0] read as zero.
- R8: `irq` is 1 exactly when both the ready flag and the interrupt-enable bit are 1. It changes at the same edge as the state it follows.
- R9: When a character strobe and a data-word read fall in the same cycle, the read wins. The flag ends at 0 and the strobed character is dropped.
- R10: A synchronous active-high reset clears the ready flag, the interrupt-enable bit, the latched code, `rd_data` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_stb | input | 1 | One-cycle character strobe from the keyboard side |
| key_code | input | 8 | Character code qualified by key_stb |
| reg_sel | input | 1 | Register select: 0 status word, 1 data word |
| rd_en | input | 1 | Bus read strobe |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 16 | Bus write data |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
State changes from a strobe, a write or a read land at the clock edge that samples them, so `irq` is due one edge after the stimulus. Read data is also due one edge after the read strobe. A status read issued in the following cycle shows the new flag after a second edge. The bench drives every input on the falling edge and samples outputs on the next falling edge, which places each comparison half a period after the edge that updated the result. A reference model in the bench advances its expected flag, enable and code once per driven cycle. The sweep covers every character code, with the enable bit varied across codes.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  parameter int BUS_W  = 16;
  parameter int CHAR_W = 8;
  parameter int RDY_POS = 15;
  parameter int IE_POS  = 14;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_DATA   = 1'b1
  } kbd_sel_e;
endpackage

// File: rtl/kbd_capture.sv
module kbd_capture #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_stb,
  input  logic [CHAR_W-1:0] key_code,
  input  logic              take,
  output logic              rdy,
  output logic              rdy_nx,
  output logic [CHAR_W-1:0] char_q
);
  logic accept;

  always_comb begin
    accept = key_stb && !rdy && !take;
    if (take)        rdy_nx = 1'b0;
    else if (accept) rdy_nx = 1'b1;
    else             rdy_nx = rdy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy    <= 1'b0;
      char_q <= '0;
    end else begin
      rdy <= rdy_nx;
      if (accept) char_q <= key_code;
    end
  end
endmodule

// File: rtl/kbd_ctrl_bit.sv
module kbd_ctrl_bit #(
  parameter int BUS_W  = 16,
  parameter int IE_POS = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stat,
  input  logic [BUS_W-1:0] wr_data,
  output logic             ie,
  output logic             ie_nx
);
  always_comb ie_nx = wr_stat ? wr_data[IE_POS] : ie;

  always_ff @(posedge clk) begin
    if (rst) ie <= 1'b0;
    else     ie <= ie_nx;
  end
endmodule

// File: rtl/kbd_readmux.sv
module kbd_readmux
  import kbd_pkg::*;
#(
  parameter int BUS_W   = 16,
  parameter int CHAR_W  = 8,
  parameter int RDY_POS = 15,
  parameter int IE_POS  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  kbd_sel_e          sel,
  input  logic              rdy,
  input  logic              ie,
  input  logic [CHAR_W-1:0] char_q,
  output logic [BUS_W-1:0]  rd_data
);
  localparam int PAD_W = BUS_W - CHAR_W;
  logic [BUS_W-1:0] stat_w, data_w, pick;

  always_comb begin
    stat_w          = '0;
    stat_w[RDY_POS] = rdy;
    stat_w[IE_POS]  = ie;
    data_w          = {{PAD_W{1'b0}}, char_q};
    pick            = (sel == SEL_DATA) ? data_w : stat_w;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= pick;
  end
endmodule

// File: rtl/kbd_regs.sv
module kbd_regs
  import kbd_pkg::*;
#(
  parameter int BUS_W   = kbd_pkg::BUS_W,
  parameter int CHAR_W  = kbd_pkg::CHAR_W,
  parameter int RDY_POS = kbd_pkg::RDY_POS,
  parameter int IE_POS  = kbd_pkg::IE_POS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_stb,
  input  logic [CHAR_W-1:0] key_code,
  input  logic              reg_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [BUS_W-1:0]  rd_data,
  output logic              irq
);
  kbd_sel_e          sel;
  logic              take, wr_stat;
  logic              rdy, rdy_nx, ie, ie_nx;
  logic [CHAR_W-1:0] char_q;

  always_comb begin
    sel     = kbd_sel_e'(reg_sel);
    take    = rd_en && (sel == SEL_DATA);
    wr_stat = wr_en && (sel == SEL_STATUS);
  end

  kbd_capture #(.CHAR_W(CHAR_W)) u_cap (
    .clk(clk), .rst(rst), .key_stb(key_stb), .key_code(key_code),
    .take(take), .rdy(rdy), .rdy_nx(rdy_nx), .char_q(char_q)
  );

  kbd_ctrl_bit #(.BUS_W(BUS_W), .IE_POS(IE_POS)) u_ctl (
    .clk(clk), .rst(rst), .wr_stat(wr_stat), .wr_data(wr_data),
    .ie(ie), .ie_nx(ie_nx)
  );

  kbd_readmux #(.BUS_W(BUS_W), .CHAR_W(CHAR_W), .RDY_POS(RDY_POS), .IE_POS(IE_POS)) u_rmx (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel), .rdy(rdy), .ie(ie),
    .char_q(char_q), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= rdy_nx && ie_nx;
  end
endmodule

// File: rtl/kbd_regs_chk.sv
module kbd_regs_chk #(
  parameter int BUS_W  = 16,
  parameter int CHAR_W = 8,
  parameter int IE_POS = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              key_stb,
  input logic              reg_sel,
  input logic              rd_en,
  input logic              wr_en,
  input logic [BUS_W-1:0]  wr_data,
  input logic [BUS_W-1:0]  rd_data,
  input logic              irq,
  input logic              rdy,
  input logic              ie,
  input logic [CHAR_W-1:0] char_q
);
  a_r3_capture: assert property (@(posedge clk) disable iff (rst)
    key_stb && !rdy && !(rd_en && reg_sel) |=> rdy);

  a_r4_locked: assert property (@(posedge clk) disable iff (rst)
    rdy && !(rd_en && reg_sel) |=> rdy && $stable(char_q));

  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    rd_en && reg_sel |=> !rdy);

  a_r6_ie_write: assert property (@(posedge clk) disable iff (rst)
    wr_en && !reg_sel |=> ie == $past(wr_data[IE_POS]));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rd_en && reg_sel |=> rd_data[BUS_W-1:CHAR_W] == '0);

  a_r7_low_zero: assert property (@(posedge clk) disable iff (rst)
    rd_en && !reg_sel |=> rd_data[IE_POS-1:0] == '0);

  a_r8_irq: assert property (@(posedge clk) disable iff (rst)
    irq == (rdy && ie));

  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind kbd_regs kbd_regs_chk #(.BUS_W(BUS_W), .CHAR_W(CHAR_W), .IE_POS(IE_POS)) u_chk (
  .clk(clk), .rst(rst), .key_stb(key_stb), .reg_sel(reg_sel), .rd_en(rd_en),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
  .rdy(rdy), .ie(ie), .char_q(char_q)
);

// File: tb/kbd_regs_bench.sv
`timescale 1ns/1ps
module kbd_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        key_stb = 1'b0;
  logic [7:0]  key_code = '0;
  logic        reg_sel = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  bit       m_rdy = 1'b0;
  bit       m_ie = 1'b0;
  bit [7:0] m_chr = '0;

  always #10 clk = ~clk;

  kbd_regs u_kbd_regs (
    .clk(clk), .rst(rst), .key_stb(key_stb), .key_code(key_code),
    .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle();
    key_stb = 0; rd_en = 0; wr_en = 0;
  endtask

  // One driven cycle, then sample at the following falling edge.
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic strobe(input logic [7:0] c);
    key_stb = 1; key_code = c;
    if (!m_rdy) begin m_rdy = 1; m_chr = c; end
    step();
    chk("R8 irq after strobe", {15'd0, irq}, {15'd0, m_rdy & m_ie});
  endtask

  task automatic rd_status();
    rd_en = 1; reg_sel = 0;
    step();
    chk("R7 status word", rd_data, {m_rdy, m_ie, 14'd0});
  endtask

  task automatic rd_data_word();
    rd_en = 1; reg_sel = 1;
    step();
    chk("R2 data word", rd_data, {8'd0, m_chr});
    m_rdy = 0;
    chk("R5 irq after data read", {15'd0, irq}, 16'd0);
  endtask

  task automatic wr_reg(input logic s, input logic [15:0] v);
    wr_en = 1; reg_sel = s; wr_data = v;
    if (!s) m_ie = v[14];
    step();
    chk("R6 irq after write", {15'd0, irq}, {15'd0, m_rdy & m_ie});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R10 reset rd_data", rd_data, 16'd0);
    chk("R10 reset irq", {15'd0, irq}, 16'd0);
    rd_status();
    chk("R10 reset flag and enable", rd_data, 16'h0000);

    // R1: read data is held while no read strobe is given
    strobe(8'h41);
    rd_status();
    step(); step();
    chk("R1 held read data", rd_data, 16'h8000);
    rd_data_word();
    rd_status();

    // R6: data-word write ignored; status write touches only bit 14
    strobe(8'h33);
    wr_reg(1'b1, 16'hFFFF);
    rd_data_word();
    chk("R6 data write ignored", rd_data, 16'h0033);
    wr_reg(1'b0, 16'hBFFF);
    rd_status();
    chk("R6 only bit14 written", rd_data, 16'h0000);
    wr_reg(1'b0, 16'h4000);
    rd_status();
    chk("R6 enable set", rd_data, 16'h4000);

    // R9: strobe and data read in the same cycle
    strobe(8'h10);
    key_stb = 1; key_code = 8'h99; rd_en = 1; reg_sel = 1;
    step();
    chk("R9 read returns old code", rd_data, 16'h0010);
    m_rdy = 0;
    chk("R9 irq low", {15'd0, irq}, 16'd0);
    rd_status();
    chk("R9 flag clear, code dropped", rd_data, 16'h4000);
    rd_data_word();
    chk("R9 latched code kept", rd_data, 16'h0010);

    // Sweep all codes with varying enable; R3, R4, R5, R8
    for (int c = 0; c < 256; c++) begin
      wr_reg(1'b0, (c % 3 == 0) ? 16'h4000 : 16'h0000);
      strobe(c[7:0]);
      chk("R3 flag set", {15'd0, m_rdy}, 16'd1);
      strobe(c[7:0] ^ 8'h5A);
      rd_status();
      chk("R8 irq level", {15'd0, irq}, {15'd0, m_ie});
      rd_data_word();
      chk("R4 dropped second code", rd_data, {8'd0, c[7:0]});
      rd_status();
    end

    // R10: reset mid-operation
    wr_reg(1'b0, 16'h4000);
    strobe(8'h7E);
    rst = 1;
    step();
    rst = 0;
    m_rdy = 0; m_ie = 0; m_chr = 0;
    chk("R10 rd_data cleared", rd_data, 16'd0);
    chk("R10 irq cleared", {15'd0, irq}, 16'd0);
    rd_status();
    rd_data_word();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule